// File: doc/BRIEF.md
# Secondary Function Access Gate

This block sits between the host register path and the register file of a function that may run as a secondary (virtual) function. When the function is secondary and marked offline, every host access except one to the status register is stopped at the gate: reads come back as zero and writes never reach the register file. An attempt to enable the controller while offline is refused with a one-cycle failure pulse instead of a start pulse.

On every reset the block issues a one-cycle load of the controller status value. An offline secondary function gets the fatal indication; an online secondary function and the primary get zero. On a function-level reset it also recomputes the active resource sizes. A secondary function derives them from its allocated queue and interrupt counts. The primary adds its private counts to its pending flexible counts and latches those pending counts as active. A controller-level reset leaves the sizes alone. One cycle after the sizes change, the interrupt table-size field follows as the new size minus one.

Top module: `sfg_top`

## Requirements
- R1: With `is_vf`=1 and `online`=0, a read whose address differs from the status offset (0x1C) returns `host_rdata`=0 and does not assert `rf_valid`.
- R2: With `is_vf`=1 and `online`=0, a write whose address differs from 0x1C does not assert `rf_valid`, so nothing reaches the register file.
- R3: An access to address 0x1C always passes with its address, data and direction unchanged. Any access passes when `online`=1 or `is_vf`=0, and `host_rdata` then equals `rf_rdata`.
- R4: `enable_req` in cycle k gives `enable_fail`=1 in cycle k+1 if `is_vf`=1 and `online`=0 in cycle k, and `enable_go`=1 otherwise. The two pulses never occur together.
- R5: `reset_req` in cycle k gives `csts_load`=1 for exactly cycle k+1. `csts_value` then has bit 1 (fatal) set if `is_vf`=1 and `online`=0 in cycle k, and is zero otherwise.
- R6: A function reset (`reset_kind`=1) with `is_vf`=1 sets `act_ioqp` to `vf_q_cnt`-1, or to 0 when `vf_q_cnt` is 0.
- R7: A function reset with `is_vf`=1 sets `act_msix` to `vf_irq_cnt`, or to 1 when `vf_irq_cnt` is 0.
- R8: A function reset with `is_vf`=0 copies `pf_q_flex_pend`/`pf_irq_flex_pend` to `pf_q_flex_act`/`pf_irq_flex_act`. It sets `act_ioqp` to `pf_q_priv`+`pf_q_flex_pend`-1 (0 if the sum is 0) and `act_msix` to `pf_irq_priv`+`pf_irq_flex_pend`.
- R9: A controller reset (`reset_kind`=0) leaves `act_ioqp`, `act_msix`, the active flexible counts and `msix_ts` unchanged.
- R10: One cycle after a function reset updates `act_msix`, `msix_ts` equals `act_msix`-1, or 0 when `act_msix` is 0.
- R11: After power-on reset, `act_ioqp`=0, `act_msix`=1, `msix_ts`=0, `csts_load`=0, `enable_go`=0, `enable_fail`=0, and the active flexible counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| is_vf | input | 1 | Strap: 1 when the function is secondary |
| online | input | 1 | Secondary function online flag |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | Host access is a write |
| acc_addr | input | 12 | Host byte address |
| acc_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data returned to host |
| rf_valid | output | 1 | Access forwarded to register file |
| rf_write | output | 1 | Forwarded access is a write |
| rf_addr | output | 12 | Forwarded address |
| rf_wdata | output | 32 | Forwarded write data |
| rf_rdata | input | 32 | Register file read data |
| enable_req | input | 1 | Host requests controller enable |
| enable_go | output | 1 | Controller start permitted |
| enable_fail | output | 1 | Controller start refused |
| reset_req | input | 1 | Reset event pulse |
| reset_kind | input | 1 | 0 controller reset, 1 function reset |
| vf_q_cnt | input | 16 | Queues allocated to the secondary function |
| vf_irq_cnt | input | 16 | Interrupts allocated to the secondary function |
| pf_q_priv | input | 16 | Primary private queue count |
| pf_irq_priv | input | 16 | Primary private interrupt count |
| pf_q_flex_pend | input | 16 | Primary pending flexible queues |
| pf_irq_flex_pend | input | 16 | Primary pending flexible interrupts |
| pf_q_flex_act | output | 16 | Primary active flexible queues |
| pf_irq_flex_act | output | 16 | Primary active flexible interrupts |
| act_ioqp | output | 17 | Active I/O queue pairs |
| act_msix | output | 17 | Active interrupt table size |
| msix_ts | output | 17 | Table-size field (size minus one) |
| csts_load | output | 1 | Load strobe for the status register |
| csts_value | output | 32 | Status value to load |

## Verification
Accesses are tried at the status offset, at a neighbouring offset and at a distant one. Each is run offline-secondary, online-secondary and primary, which separates a correct address compare from a gate that blocks or passes everything. Function resets use zero counts and nonzero counts, so the minus-one, minimum-one and saturation paths are each seen. A controller reset issued with changed counts shows whether the sizes are wrongly recomputed. Status loads come both offline and online, and the table-size field is sampled a cycle after each size change to expose a wrong stage or a missing decrement.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
    typedef enum logic {
        RST_CTRL = 1'b0,
        RST_FUNC = 1'b1
    } rst_kind_e;
endpackage

// File: rtl/sfg_access_gate.sv
module sfg_access_gate #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int STS_OFF = 'h1C
) (
    input  logic              is_vf,
    input  logic              online,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_valid,
    output logic              rf_write,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFF);

    logic is_sts;
    logic fenced;
    logic blocked;

    always_comb begin
        is_sts     = (acc_addr == STS_A);
        fenced     = is_vf && !online;
        blocked    = fenced && !is_sts;
        rf_valid   = acc_valid && !blocked;
        rf_write   = acc_write;
        rf_addr    = acc_addr;
        rf_wdata   = acc_wdata;
        host_rdata = blocked ? '0 : rf_rdata;
    end
endmodule

// File: rtl/sfg_size_calc.sv
module sfg_size_calc #(
    parameter int CNT_W = 16,
    parameter int SZ_W  = CNT_W + 1
) (
    input  logic             is_vf,
    input  logic [CNT_W-1:0] vf_q_cnt,
    input  logic [CNT_W-1:0] vf_irq_cnt,
    input  logic [CNT_W-1:0] pf_q_priv,
    input  logic [CNT_W-1:0] pf_irq_priv,
    input  logic [CNT_W-1:0] pf_q_flex,
    input  logic [CNT_W-1:0] pf_irq_flex,
    output logic [SZ_W-1:0]  ioqp_new,
    output logic [SZ_W-1:0]  msix_new
);
    logic [SZ_W-1:0] vf_q_ext;
    logic [SZ_W-1:0] vf_i_ext;
    logic [SZ_W-1:0] pf_q_sum;
    logic [SZ_W-1:0] pf_i_sum;

    always_comb begin
        vf_q_ext = SZ_W'(vf_q_cnt);
        vf_i_ext = SZ_W'(vf_irq_cnt);
        pf_q_sum = SZ_W'(pf_q_priv) + SZ_W'(pf_q_flex);
        pf_i_sum = SZ_W'(pf_irq_priv) + SZ_W'(pf_irq_flex);
        if (is_vf) begin
            ioqp_new = (vf_q_ext == '0) ? '0 : vf_q_ext - 1'b1;
            msix_new = (vf_i_ext == '0) ? SZ_W'(1) : vf_i_ext;
        end else begin
            ioqp_new = (pf_q_sum == '0) ? '0 : pf_q_sum - 1'b1;
            msix_new = pf_i_sum;
        end
    end
endmodule

// File: rtl/sfg_start_guard.sv
module sfg_start_guard (
    input  logic is_vf,
    input  logic online,
    input  logic enable_req,
    output logic start_ok,
    output logic start_bad
);
    logic fenced;

    always_comb begin
        fenced    = is_vf && !online;
        start_ok  = enable_req && !fenced;
        start_bad = enable_req && fenced;
    end
endmodule

// File: rtl/sfg_top.sv
module sfg_top #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    parameter int STS_OFF   = 'h1C,
    parameter int FATAL_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_vf,
    input  logic              online,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              rf_valid,
    output logic              rf_write,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic              enable_req,
    output logic              enable_go,
    output logic              enable_fail,
    input  logic              reset_req,
    input  logic              reset_kind,
    input  logic [CNT_W-1:0]  vf_q_cnt,
    input  logic [CNT_W-1:0]  vf_irq_cnt,
    input  logic [CNT_W-1:0]  pf_q_priv,
    input  logic [CNT_W-1:0]  pf_irq_priv,
    input  logic [CNT_W-1:0]  pf_q_flex_pend,
    input  logic [CNT_W-1:0]  pf_irq_flex_pend,
    output logic [CNT_W-1:0]  pf_q_flex_act,
    output logic [CNT_W-1:0]  pf_irq_flex_act,
    output logic [CNT_W:0]    act_ioqp,
    output logic [CNT_W:0]    act_msix,
    output logic [CNT_W:0]    msix_ts,
    output logic              csts_load,
    output logic [DATA_W-1:0] csts_value
);
    import sfg_pkg::*;

    localparam int SZ_W = CNT_W + 1;
    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFF);

    typedef struct packed {
        logic [SZ_W-1:0]   ioqp;
        logic [SZ_W-1:0]   msix;
        logic [SZ_W-1:0]   ts;
        logic              ts_pend;
        logic [CNT_W-1:0]  qflex;
        logic [CNT_W-1:0]  iflex;
        logic              cs_ld;
        logic [DATA_W-1:0] cs_val;
        logic              go;
        logic              fail;
    } st_t;

    st_t st_d, st_q;

    logic [SZ_W-1:0] ioqp_new;
    logic [SZ_W-1:0] msix_new;
    logic            start_ok;
    logic            start_bad;
    rst_kind_e       kind;

    sfg_access_gate #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STS_OFF(STS_OFF)
    ) u_gate (
        .is_vf     (is_vf),
        .online    (online),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .rf_rdata  (rf_rdata),
        .rf_valid  (rf_valid),
        .rf_write  (rf_write),
        .rf_addr   (rf_addr),
        .rf_wdata  (rf_wdata),
        .host_rdata(host_rdata)
    );

    sfg_size_calc #(
        .CNT_W(CNT_W),
        .SZ_W (SZ_W)
    ) u_size (
        .is_vf      (is_vf),
        .vf_q_cnt   (vf_q_cnt),
        .vf_irq_cnt (vf_irq_cnt),
        .pf_q_priv  (pf_q_priv),
        .pf_irq_priv(pf_irq_priv),
        .pf_q_flex  (pf_q_flex_pend),
        .pf_irq_flex(pf_irq_flex_pend),
        .ioqp_new   (ioqp_new),
        .msix_new   (msix_new)
    );

    sfg_start_guard u_guard (
        .is_vf     (is_vf),
        .online    (online),
        .enable_req(enable_req),
        .start_ok  (start_ok),
        .start_bad (start_bad)
    );

    always_comb begin
        kind          = rst_kind_e'(reset_kind);
        st_d          = st_q;
        st_d.cs_ld    = 1'b0;
        st_d.ts_pend  = 1'b0;
        st_d.go       = start_ok;
        st_d.fail     = start_bad;
        if (st_q.ts_pend) begin
            st_d.ts = (st_q.msix == '0) ? '0 : st_q.msix - 1'b1;
        end
        if (reset_req) begin
            st_d.cs_ld  = 1'b1;
            st_d.cs_val = '0;
            st_d.cs_val[FATAL_BIT] = is_vf && !online;
            if (kind == RST_FUNC) begin
                st_d.ioqp    = ioqp_new;
                st_d.msix    = msix_new;
                st_d.ts_pend = 1'b1;
                if (!is_vf) begin
                    st_d.qflex = pf_q_flex_pend;
                    st_d.iflex = pf_irq_flex_pend;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ioqp    <= '0;
            st_q.msix    <= SZ_W'(1);
            st_q.ts      <= '0;
            st_q.ts_pend <= 1'b0;
            st_q.qflex   <= '0;
            st_q.iflex   <= '0;
            st_q.cs_ld   <= 1'b0;
            st_q.cs_val  <= '0;
            st_q.go      <= 1'b0;
            st_q.fail    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_ioqp        = st_q.ioqp;
    assign act_msix        = st_q.msix;
    assign msix_ts         = st_q.ts;
    assign pf_q_flex_act   = st_q.qflex;
    assign pf_irq_flex_act = st_q.iflex;
    assign csts_load       = st_q.cs_ld;
    assign csts_value      = st_q.cs_val;
    assign enable_go       = st_q.go;
    assign enable_fail     = st_q.fail;

    p_offline_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && is_vf && !online && acc_addr != STS_A)
        |-> (host_rdata == '0 && !rf_valid));

    p_offline_write_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && is_vf && !online && acc_addr != STS_A)
        |-> !rf_valid);

    p_status_passes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr == STS_A) |-> (rf_valid && rf_addr == acc_addr));

    p_start_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable_go && enable_fail));

    p_fail_when_fenced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_req && is_vf && !online) |=> (enable_fail && !enable_go));

    p_csts_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> csts_load);

    p_vf_msix_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && reset_kind && is_vf) |=> (act_msix != '0));

    p_ctrl_rst_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && !reset_kind) |=> ($stable(act_ioqp) && $stable(act_msix)));

    p_ts_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && reset_kind && is_vf && vf_irq_cnt != '0) |=> ##1
        (msix_ts == $past(act_msix) - 1'b1));
endmodule

// File: tb/sfg_top_tb.sv
module sfg_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        is_vf = 1'b1;
    logic        online = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] host_rdata;
    logic        rf_valid;
    logic        rf_write;
    logic [11:0] rf_addr;
    logic [31:0] rf_wdata;
    logic [31:0] rf_rdata = 32'hCAFE_0123;
    logic        enable_req = 1'b0;
    logic        enable_go;
    logic        enable_fail;
    logic        reset_req = 1'b0;
    logic        reset_kind = 1'b0;
    logic [15:0] vf_q_cnt = '0;
    logic [15:0] vf_irq_cnt = '0;
    logic [15:0] pf_q_priv = '0;
    logic [15:0] pf_irq_priv = '0;
    logic [15:0] pf_q_flex_pend = '0;
    logic [15:0] pf_irq_flex_pend = '0;
    logic [15:0] pf_q_flex_act;
    logic [15:0] pf_irq_flex_act;
    logic [16:0] act_ioqp;
    logic [16:0] act_msix;
    logic [16:0] msix_ts;
    logic        csts_load;
    logic [31:0] csts_value;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sfg_top u_dut (.*);

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(logic kind);
        @(negedge clk);
        reset_req  = 1'b1;
        reset_kind = kind;
        step();
        @(negedge clk);
        reset_req = 1'b0;
    endtask

    task automatic t_por_r11();
        chk("R11 ioqp", 32'(act_ioqp), 0);
        chk("R11 msix", 32'(act_msix), 1);
        chk("R11 ts", 32'(msix_ts), 0);
        chk("R11 csts_load", 32'(csts_load), 0);
        chk("R11 go/fail", {30'd0, enable_go, enable_fail}, 0);
        chk("R11 flex", {pf_q_flex_act, pf_irq_flex_act}, 0);
    endtask

    task automatic t_gate_offline();
        @(negedge clk);
        is_vf = 1'b1; online = 1'b0;
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 12'h014;
        #1;
        chk("R1 read data", host_rdata, 0);
        chk("R1 read fwd", 32'(rf_valid), 0);
        acc_addr = 12'h1C0;
        #1;
        chk("R1 far read fwd", 32'(rf_valid), 0);
        acc_write = 1'b1; acc_addr = 12'h020; acc_wdata = 32'h1;
        #1;
        chk("R2 write fwd", 32'(rf_valid), 0);
        acc_addr = 12'h01C;
        #1;
        chk("R3 sts write fwd", {rf_valid, rf_write, 18'd0, rf_addr}, {1'b1, 1'b1, 18'd0, 12'h01C});
        acc_write = 1'b0;
        #1;
        chk("R3 sts read data", host_rdata, 32'hCAFE_0123);
        acc_valid = 1'b0;
    endtask

    task automatic t_gate_open();
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 12'h014; acc_wdata = 32'h55AA;
        is_vf = 1'b1; online = 1'b1;
        #1;
        chk("R3 online fwd", {rf_valid, 15'd0, rf_wdata[15:0]}, {1'b1, 15'd0, 16'h55AA});
        is_vf = 1'b0; online = 1'b0; acc_write = 1'b0;
        #1;
        chk("R3 primary read", {rf_valid, 31'd0}, {1'b1, 31'd0});
        chk("R3 primary data", host_rdata, 32'hCAFE_0123);
        acc_valid = 1'b0;
    endtask

    task automatic t_enable();
        @(negedge clk);
        is_vf = 1'b1; online = 1'b0; enable_req = 1'b1;
        step();
        chk("R4 offline", {30'd0, enable_go, enable_fail}, 32'd1);
        @(negedge clk);
        online = 1'b1;
        step();
        chk("R4 online", {30'd0, enable_go, enable_fail}, 32'd2);
        @(negedge clk);
        enable_req = 1'b0;
        step();
        chk("R4 idle", {30'd0, enable_go, enable_fail}, 32'd0);
    endtask

    task automatic t_vf_zero();
        @(negedge clk);
        is_vf = 1'b1; online = 1'b0; vf_q_cnt = 0; vf_irq_cnt = 0;
        do_reset(1'b1);
        chk("R5 load offline", 32'(csts_load), 1);
        chk("R5 fatal", csts_value, 32'h2);
        chk("R6 ioqp zero", 32'(act_ioqp), 0);
        chk("R7 msix floor", 32'(act_msix), 1);
        step();
        chk("R5 one cycle", 32'(csts_load), 0);
        chk("R10 ts", 32'(msix_ts), 0);
    endtask

    task automatic t_vf_counts();
        @(negedge clk);
        is_vf = 1'b1; online = 1'b1; vf_q_cnt = 5; vf_irq_cnt = 3;
        do_reset(1'b1);
        chk("R5 online value", csts_value, 0);
        chk("R6 ioqp", 32'(act_ioqp), 4);
        chk("R7 msix", 32'(act_msix), 3);
        step();
        chk("R10 ts", 32'(msix_ts), 2);
    endtask

    task automatic t_ctrl_reset();
        @(negedge clk);
        vf_q_cnt = 9; vf_irq_cnt = 8; online = 1'b0;
        do_reset(1'b0);
        chk("R5 ctrl load", {csts_load, csts_value[30:0]}, {1'b1, 31'h2});
        chk("R9 ioqp", 32'(act_ioqp), 4);
        chk("R9 msix", 32'(act_msix), 3);
        step();
        chk("R9 ts", 32'(msix_ts), 2);
    endtask

    task automatic t_pf();
        @(negedge clk);
        is_vf = 1'b0; online = 1'b0;
        pf_q_priv = 4; pf_q_flex_pend = 3; pf_irq_priv = 2; pf_irq_flex_pend = 5;
        do_reset(1'b1);
        chk("R5 primary value", csts_value, 0);
        chk("R8 flex act", {pf_q_flex_act, pf_irq_flex_act}, {16'd3, 16'd5});
        chk("R8 ioqp", 32'(act_ioqp), 6);
        chk("R8 msix", 32'(act_msix), 7);
        step();
        chk("R10 ts", 32'(msix_ts), 6);
        @(negedge clk);
        pf_q_flex_pend = 1; pf_irq_flex_pend = 1;
        do_reset(1'b0);
        chk("R9 flex kept", {pf_q_flex_act, pf_irq_flex_act}, {16'd3, 16'd5});
        @(negedge clk);
        pf_q_priv = 0; pf_q_flex_pend = 0; pf_irq_priv = 0; pf_irq_flex_pend = 0;
        do_reset(1'b1);
        chk("R8 ioqp sat", 32'(act_ioqp), 0);
        chk("R8 msix zero", 32'(act_msix), 0);
        step();
        chk("R10 ts zero", 32'(msix_ts), 0);
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #7;
        rst_n = 1'b1;
        step();
        t_por_r11();
        t_gate_offline();
        t_gate_open();
        t_enable();
        t_vf_zero();
        t_vf_counts();
        t_ctrl_reset();
        t_pf();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule